// File: doc/BRIEF.md
# Two-Stage Round-Robin Request Matcher

This block pairs a set of requesters with a set of resources in one clock cycle, the way a network router hands out output virtual channels or crossbar ports. Each cycle it takes a request matrix, one bit for every requester and resource pair, and returns a grant matrix of the same shape. No requester is granted more than one resource, and no resource is granted to more than one requester.

The match is made in two passes. In the first pass every resource has its own round-robin arbiter, which picks one of the requesters asking for it. One requester can win several resources in that pass. In the second pass every requester has its own round-robin arbiter, which keeps one of the resources it won and drops the rest. The grant is combinational in the request, so it appears in the same cycle as the request. Only the priority pointers are registered.

A pointer moves past the input it served, so that input has the lowest priority on the next cycle. A first-pass pointer moves only when its pick survives the second pass. A resource whose winner dropped it therefore offers that same requester first priority again on the next cycle.

Top module: `sep_allocator`

## Requirements
- R1: A grant bit is 1 only where the request bit for the same pair is 1. Pair (requester i, resource j) is bit i*NUM_RES+j of both `req_i` and `gnt_o`.
- R2: Each requester holds at most one grant per cycle.
- R3: Each resource is granted to at most one requester per cycle.
- R4: After reset every pointer is 0. With every request bit set, requester 0 wins every resource in the first pass and keeps resource 0, so the grant is 12'h001 in the default 3x4 configuration.
- R5: After requester i is granted resource j, that resource's first-pass arbiter gives the highest priority to requester (i+1) mod NUM_REQ on the next cycle.
- R6: A first-pass pointer does not move when its pick is dropped in the second pass.
- R7: After requester i is granted resource j, that requester's second-pass arbiter gives the highest priority to resource (j+1) mod NUM_RES on the next cycle.
- R8: With no request bits set, every grant bit is 0 and no pointer changes.
- R9: The grant responds to the request in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears every pointer to 0 |
| req_i | input | NUM_REQ*NUM_RES | Request matrix, bit i*NUM_RES+j is requester i asking for resource j |
| gnt_o | output | NUM_REQ*NUM_RES | Grant matrix, same bit layout as req_i |

## Verification
In a single cycle, one requester can win several resources in the first pass. The second pass then discards all but one of those wins. So a pointer commit and a pointer hold happen together, across different first-pass arbiters.

Full-matrix and row-heavy directed patterns provoke this, and so do dense random matrices. The bench judges the result by comparing every grant against a bench model that moves a first-pass pointer only for picks that survived the second pass. A directed pair of cycles separately shows that a dropped resource still offers the same requester first priority on the next cycle.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

    // Circular successor of an index in a ring of n entries
    function automatic int rr_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rr_pick.sv
// Combinational round-robin pick: first requesting input at or after ptr
module rr_pick #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [PW-1:0] idx
);

    always_comb begin
        logic found;
        int   p;
        gnt   = '0;
        idx   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            p = int'(ptr) + k;
            if (p >= N) p = p - N;
            if (!found && req[p]) begin
                found  = 1'b1;
                gnt[p] = 1'b1;
                idx    = PW'(p);
            end
        end
    end

endmodule

// File: rtl/rr_state.sv
// Registered priority pointer of one round-robin arbiter
module rr_state #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [PW-1:0] win_idx,
    output logic [PW-1:0] ptr_o
);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd) begin
            st_d.ptr = PW'(alloc_pkg::rr_next(int'(win_idx), N));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;

    AST_PTR_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                       !upd |=> $stable(ptr_o));               // R6
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                       int'(ptr_o) < N);                       // R5

endmodule

// File: rtl/sep_allocator.sv
module sep_allocator #(
    parameter int NUM_REQ = 3,
    parameter int NUM_RES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REQ*NUM_RES-1:0] req_i,
    output logic [NUM_REQ*NUM_RES-1:0] gnt_o
);

    localparam int RPW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam int MPW = (NUM_RES > 1) ? $clog2(NUM_RES) : 1;

    // First pass: one arbiter per resource, over requesters
    logic [NUM_REQ-1:0] col_req  [NUM_RES];
    logic [NUM_REQ-1:0] col_win  [NUM_RES];
    logic [RPW-1:0]     col_idx  [NUM_RES];
    logic [RPW-1:0]     col_ptr  [NUM_RES];
    logic [NUM_REQ-1:0] fin_col  [NUM_RES];
    logic               col_upd  [NUM_RES];

    // Second pass: one arbiter per requester, over won resources
    logic [NUM_RES-1:0] row_req  [NUM_REQ];
    logic [NUM_RES-1:0] row_gnt  [NUM_REQ];
    logic [MPW-1:0]     row_idx  [NUM_REQ];
    logic [MPW-1:0]     row_ptr  [NUM_REQ];

    always_comb begin
        for (int j = 0; j < NUM_RES; j++) begin
            for (int i = 0; i < NUM_REQ; i++) begin
                col_req[j][i] = req_i[i*NUM_RES + j];
            end
        end
    end

    generate
        for (genvar j = 0; j < NUM_RES; j++) begin : g_res
            rr_pick #(.N(NUM_REQ), .PW(RPW)) u_pick (
                .req (col_req[j]),
                .ptr (col_ptr[j]),
                .gnt (col_win[j]),
                .idx (col_idx[j])
            );
            rr_state #(.N(NUM_REQ), .PW(RPW)) u_ptr (
                .clk     (clk),
                .rst_n   (rst_n),
                .upd     (col_upd[j]),
                .win_idx (col_idx[j]),
                .ptr_o   (col_ptr[j])
            );
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NUM_REQ; i++) begin
            for (int j = 0; j < NUM_RES; j++) begin
                row_req[i][j] = col_win[j][i];
            end
        end
    end

    generate
        for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
            rr_pick #(.N(NUM_RES), .PW(MPW)) u_pick (
                .req (row_req[i]),
                .ptr (row_ptr[i]),
                .gnt (row_gnt[i]),
                .idx (row_idx[i])
            );
            rr_state #(.N(NUM_RES), .PW(MPW)) u_ptr (
                .clk     (clk),
                .rst_n   (rst_n),
                .upd     (|row_gnt[i]),
                .win_idx (row_idx[i]),
                .ptr_o   (row_ptr[i])
            );
        end
    endgenerate

    // Final grants; a first-pass pointer commits only for surviving picks
    always_comb begin
        for (int i = 0; i < NUM_REQ; i++) begin
            for (int j = 0; j < NUM_RES; j++) begin
                gnt_o[i*NUM_RES + j] = row_gnt[i][j];
                fin_col[j][i]        = row_gnt[i][j];
            end
        end
        for (int j = 0; j < NUM_RES; j++) begin
            col_upd[j] = |fin_col[j];
        end
    end

    AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
                        (gnt_o & ~req_i) == '0);               // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                        (req_i == '0) |-> (gnt_o == '0));      // R8

    generate
        for (genvar i = 0; i < NUM_REQ; i++) begin : g_row_chk
            AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
                                $onehot0(row_gnt[i]));         // R2
        end
        for (genvar j = 0; j < NUM_RES; j++) begin : g_col_chk
            AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
                                $onehot0(fin_col[j]));         // R3
            AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
                                (fin_col[j] != '0) |=>
                                (int'(col_ptr[j]) ==
                                 alloc_pkg::rr_next(int'($past(col_idx[j])), NUM_REQ))); // R5
        end
    endgenerate

endmodule

// File: tb/tb_sep_allocator.sv
`timescale 1ns/1ps
module tb_sep_allocator;

    localparam int R = 3;
    localparam int M = 4;
    localparam int W = R*M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] req = '0;
    logic [W-1:0] gnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int p1 [M];
    int p2 [R];

    always #4 clk = ~clk;

    sep_allocator #(.NUM_REQ(R), .NUM_RES(M)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .gnt_o (gnt)
    );

    function automatic logic [W-1:0] model_gnt(input logic [W-1:0] r);
        int pick [M];
        logic [W-1:0] g;
        g = '0;
        for (int j = 0; j < M; j++) begin
            pick[j] = -1;
            for (int k = 0; k < R; k++) begin
                int i;
                i = (p1[j] + k) % R;
                if (pick[j] < 0 && r[i*M + j]) pick[j] = i;
            end
        end
        for (int i = 0; i < R; i++) begin
            bit got;
            got = 0;
            for (int k = 0; k < M; k++) begin
                int j;
                j = (p2[i] + k) % M;
                if (!got && pick[j] == i) begin
                    got = 1;
                    g[i*M + j] = 1'b1;
                end
            end
        end
        return g;
    endfunction

    task automatic model_update(input logic [W-1:0] g);
        for (int i = 0; i < R; i++)
            for (int j = 0; j < M; j++)
                if (g[i*M + j]) begin
                    p1[j] = (i + 1) % R;
                    p2[i] = (j + 1) % M;
                end
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_shape(input logic [W-1:0] r, input logic [W-1:0 ] g);
        int n;
        chk("R1 grant within request", g & ~r, '0);
        for (int i = 0; i < R; i++) begin
            n = 0;
            for (int j = 0; j < M; j++) n += int'(g[i*M + j]);
            chk("R2 one grant per requester", W'(n > 1), '0);
        end
        for (int j = 0; j < M; j++) begin
            n = 0;
            for (int i = 0; i < R; i++) n += int'(g[i*M + j]);
            chk("R3 one grant per resource", W'(n > 1), '0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < M; j++) p1[j] = 0;
        for (int i = 0; i < R; i++) p2[i] = 0;
    endtask

    // Drive at the falling edge, check the combinational grant (R9) before the rising edge
    task automatic step(input string tag, input logic [W-1:0] r, input logic [W-1:0] exp_lit, input bit use_lit);
        logic [W-1:0] e;
        @(negedge clk);
        req = r;
        #1;
        e = model_gnt(r);
        if (use_lit) chk(tag, gnt, exp_lit);
        chk({tag, " / R9 same-cycle model"}, gnt, e);
        chk_shape(r, gnt);
        model_update(e);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();

        // Reset state: no request, no grant
        #1;
        chk("R8 idle after reset", gnt, '0);

        // R4: pointers at 0, full matrix
        step("R4 reset priority", {W{1'b1}}, 12'h001, 1);
        // R5 and R7: requester 1 first for resource 0, requester 0 moves to resource 1
        step("R5 R7 rotation", {W{1'b1}}, 12'h012, 1);

        // R8: an idle cycle leaves every pointer unchanged
        do_reset();
        step("R4 reset priority", {W{1'b1}}, 12'h001, 1);
        step("R8 idle no grant", '0, 12'h000, 1);
        step("R8 state held", {W{1'b1}}, 12'h012, 1);

        // R6: requester 0 wins resources 0 and 1, keeps 0; resource 1 pointer holds
        do_reset();
        step("R6 multi win", 12'h003, 12'h001, 1);
        step("R6 dropped pick keeps priority", 12'h022, 12'h002, 1);

        // R7: single requester cycles through its resources
        do_reset();
        step("R7 row rotate a", 12'h00F, 12'h001, 1);
        step("R7 row rotate b", 12'h00F, 12'h002, 1);
        step("R7 row rotate c", 12'h00F, 12'h004, 1);
        step("R7 row rotate d", 12'h00F, 12'h008, 1);
        step("R7 row wrap", 12'h00F, 12'h001, 1);

        // R5: one resource contested by all requesters rotates
        do_reset();
        step("R5 col rotate a", 12'h111, 12'h001, 1);
        step("R5 col rotate b", 12'h111, 12'h010, 1);
        step("R5 col rotate c", 12'h111, 12'h100, 1);
        step("R5 col wrap", 12'h111, 12'h001, 1);

        // Random dense and sparse matrices against the model (R4 R5 R6 R7 R8)
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] r;
            case (n % 4)
                0:       r = W'($urandom);
                1:       r = W'($urandom & $urandom);
                2:       r = W'($urandom | $urandom);
                default: r = ($urandom % 5 == 0) ? '0 : W'($urandom & $urandom & $urandom);
            endcase
            step("R5 R6 R7 random", r, '0, 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule